// File: doc/BRIEF.md
# Real-Time Clock Prescaler and Periodic Rate Generator

This block turns a 32.768 kHz time-base enable into the two timing events a real-time clock needs. A single binary divider chain advances on each time-base tick. Its full wrap produces the one-second update pulse that steps the calendar core, and a selected tap of the same chain produces a programmable periodic event. A small update-in-progress window is derived from the chain so that software can avoid reading the calendar while it is about to change.

A 7-bit control word has two fields. The mode field, bits 6 to 4, selects the chain state. Value 010 runs the chain, value 111 holds it in reset, and any other value freezes it. The rate field, bits 3 to 0, selects the periodic tap. Each event sets a sticky flag. The interrupt request is raised while a flag is set and its enable is high. A one-cycle clear input, which models the read of the flag register, empties both flags.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset the control word reads 7'h26 (mode 010, rate 0110). The flags, the update pulse, the update window and the interrupt request are all 0. The chain restarts at its half-way point, so the first update pulse comes 16384 ticks after reset is released.
- R2: In mode 010, `upd_pulse` is high for exactly one cycle once every 32768 time-base ticks.
- R3: Mode 111 holds the chain at its half-way point. The first update pulse comes exactly 16384 ticks (500 ms) after the mode returns to 010.
- R4: Any mode other than 010 or 111 freezes the chain. No update or periodic event occurs while frozen. On return to 010, counting continues from the frozen value, which delays the next update by the number of frozen cycles.
- R5: With rate code c from 3 to 15, the periodic event repeats every 2^(c-1) ticks. Code 3 gives 4 ticks (8192 Hz), code 6 gives 32 ticks (1024 Hz) and code 15 gives 16384 ticks (2 Hz). After the chain leaves reset, the first event lands 2^(c-1) ticks later.
- R6: Rate code 0 produces no periodic event.
- R7: Rate codes 1 and 2 give the same periods as codes 8 and 9: 128 and 256 ticks.
- R8: `uip` rises 8 ticks before each update pulse, stays high through those 8 ticks, and is low in the cycle in which `upd_pulse` is high.
- R9: `per_flag` and `upd_flag` are set by their events and stay set until a `flag_clr` cycle clears both. If an event and a clear occur in the same cycle, the flag stays set.
- R10: `irq` is high exactly when a set flag has its enable high (`per_en` for the periodic flag, `upd_en` for the update flag).
- R11: A cycle with `tick_32k` low does not advance the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | Time-base enable, one cycle per 32.768 kHz period |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 7 | Control word: [6:4] mode, [3:0] rate code |
| ctl_rdata | output | 7 | Current control word |
| per_en | input | 1 | Periodic interrupt enable |
| upd_en | input | 1 | Update interrupt enable |
| flag_clr | input | 1 | Clears both flags (flag register read) |
| upd_pulse | output | 1 | One-cycle one-second update event |
| uip | output | 1 | Update-in-progress window |
| per_flag | output | 1 | Sticky periodic event flag |
| upd_flag | output | 1 | Sticky update event flag |
| irq | output | 1 | Interrupt request |

## Verification
Every result is registered. The update pulse, the window, both flags and the interrupt request therefore appear in the cycle after the edge at which the counted tick is taken. A control write counts as follows. The chain follows the old mode on the write edge and the new mode from the next edge. So after a release from hold, the first update is due exactly 16384 edges after the write edge, and the first periodic event is due 2^(c-1) edges after it. The bench keeps its own edge counter. Its driver pushes the predicted edge number of each update into a queue. A monitor sampling at the falling edge pops the queue on each pulse and compares the edge numbers. The flag and window checks wait until the exact predicted edge and also look one edge earlier.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;

  typedef enum logic [1:0] {
    CHAIN_RUN,
    CHAIN_HOLD,
    CHAIN_STOP
  } chain_mode_t;

  localparam logic [2:0] SEL_RUN  = 3'b010;
  localparam logic [2:0] SEL_HOLD = 3'b111;

  function automatic chain_mode_t decode_mode(input logic [2:0] sel);
    if (sel == SEL_RUN)       return CHAIN_RUN;
    else if (sel == SEL_HOLD) return CHAIN_HOLD;
    else                      return CHAIN_STOP;
  endfunction

  // Divide exponent for a rate code; 0 means no periodic output.
  function automatic int rate_exp(input logic [3:0] code, input int max_e);
    int e;
    case (code)
      4'd0:    e = 0;
      4'd1:    e = 7;
      4'd2:    e = 8;
      default: e = int'(code) - 1;
    endcase
    if (e > max_e) e = max_e;
    return e;
  endfunction

endpackage

// File: rtl/rtc_pre_ctrl.sv
module rtc_pre_ctrl #(
  parameter int SEL_W = 3,
  parameter int RATE_W = 4,
  parameter logic [SEL_W-1:0] RST_SEL = 3'b010,
  parameter logic [RATE_W-1:0] RST_RATE = 4'd6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [SEL_W+RATE_W-1:0] wdata,
  output logic [SEL_W-1:0]        sel,
  output logic [RATE_W-1:0]       rate
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel  <= RST_SEL;
      rate <= RST_RATE;
    end else if (we) begin
      sel  <= wdata[SEL_W+RATE_W-1:RATE_W];
      rate <= wdata[RATE_W-1:0];
    end
  end
endmodule

// File: rtl/rtc_pre_chain.sv
module rtc_pre_chain
  import rtc_pre_pkg::*;
#(
  parameter int DIV_W = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  chain_mode_t        mode,
  output logic [DIV_W-1:0]   cnt,
  output logic               adv,
  output logic               upd_pulse,
  output logic               uip
);
  localparam logic [DIV_W-1:0] CNT_HALF = {1'b1, {(DIV_W-1){1'b0}}};
  localparam logic [DIV_W-1:0] CNT_LAST = '1;
  localparam logic [DIV_W-1:0] CNT_UIP  = CNT_LAST - DIV_W'(UIP_LEAD - 1);

  logic [DIV_W-1:0] cnt_d;
  logic             wrap;

  assign adv  = tick && (mode == CHAIN_RUN);
  assign wrap = adv && (cnt == CNT_LAST);

  always_comb begin
    cnt_d = cnt;
    if (mode == CHAIN_HOLD) cnt_d = CNT_HALF;
    else if (adv)           cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= CNT_HALF;
      upd_pulse <= 1'b0;
      uip       <= 1'b0;
    end else begin
      cnt       <= cnt_d;
      upd_pulse <= wrap;
      uip       <= (cnt_d >= CNT_UIP);
    end
  end

  // R2
  upd_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |=> !upd_pulse);
  // R8
  uip_low_on_upd_chk: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> !uip);
  // R8
  uip_before_upd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_pulse) |-> $past(uip));
  // R3
  hold_half_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == CHAIN_HOLD) |=> (cnt == CNT_HALF));
  // R11
  no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !upd_pulse);
  // R4
  stop_no_upd_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == CHAIN_STOP) |=> !upd_pulse);
endmodule

// File: rtl/rtc_pre_rate.sv
module rtc_pre_rate
  import rtc_pre_pkg::*;
#(
  parameter int DIV_W = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cnt,
  input  logic              adv,
  input  logic [RATE_W-1:0] rate,
  output logic              per_evt
);
  localparam int MAX_E = DIV_W - 1;

  logic [MAX_E:1] low_ones;
  logic           hit;
  int             e_sel;

  for (genvar g = 1; g <= MAX_E; g++) begin : g_tap
    assign low_ones[g] = &cnt[g-1:0];
  end

  always_comb begin
    e_sel = rate_exp(rate, MAX_E);
    hit   = 1'b0;
    for (int g = 1; g <= MAX_E; g++) begin
      if (e_sel == g) hit = low_ones[g];
    end
  end

  assign per_evt = adv && (rate != '0) && hit;

  // R6
  rate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == '0) |-> !per_evt);
  // R5
  per_needs_adv_chk: assert property (@(posedge clk) disable iff (rst)
    per_evt |-> adv);
endmodule

// File: rtl/rtc_pre_flags.sv
module rtc_pre_flags (
  input  logic clk,
  input  logic rst,
  input  logic per_evt,
  input  logic upd_evt,
  input  logic clr,
  input  logic per_en,
  input  logic upd_en,
  output logic per_flag,
  output logic upd_flag,
  output logic irq
);
  logic per_d, upd_d;

  assign per_d = per_evt || (per_flag && !clr);
  assign upd_d = upd_evt || (upd_flag && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_flag <= 1'b0;
      upd_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      per_flag <= per_d;
      upd_flag <= upd_d;
      irq      <= (per_d && per_en) || (upd_d && upd_en);
    end
  end

  // R9
  per_set_chk: assert property (@(posedge clk) disable iff (rst)
    per_evt |=> per_flag);
  // R9
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !per_evt && !upd_evt) |=> (!per_flag && !upd_flag));
  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == ((per_flag && $past(per_en)) || (upd_flag && $past(upd_en))));
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pre_pkg::*;
#(
  parameter int DIV_W = 15,
  parameter int UIP_LEAD = 8,
  parameter int SEL_W = 3,
  parameter int RATE_W = 4,
  parameter logic [SEL_W-1:0] RST_SEL = 3'b010,
  parameter logic [RATE_W-1:0] RST_RATE = 4'd6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_32k,
  input  logic                    ctl_we,
  input  logic [SEL_W+RATE_W-1:0] ctl_wdata,
  output logic [SEL_W+RATE_W-1:0] ctl_rdata,
  input  logic                    per_en,
  input  logic                    upd_en,
  input  logic                    flag_clr,
  output logic                    upd_pulse,
  output logic                    uip,
  output logic                    per_flag,
  output logic                    upd_flag,
  output logic                    irq
);
  logic [SEL_W-1:0]  sel;
  logic [RATE_W-1:0] rate;
  logic [DIV_W-1:0]  cnt;
  logic              adv;
  logic              per_evt;
  logic              wrap_evt;
  chain_mode_t       mode;

  rtc_pre_ctrl #(
    .SEL_W(SEL_W), .RATE_W(RATE_W), .RST_SEL(RST_SEL), .RST_RATE(RST_RATE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .sel(sel), .rate(rate)
  );

  assign mode      = decode_mode(sel);
  assign ctl_rdata = {sel, rate};

  rtc_pre_chain #(.DIV_W(DIV_W), .UIP_LEAD(UIP_LEAD)) u_chain (
    .clk(clk), .rst(rst), .tick(tick_32k), .mode(mode),
    .cnt(cnt), .adv(adv), .upd_pulse(upd_pulse), .uip(uip)
  );

  rtc_pre_rate #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst(rst), .cnt(cnt), .adv(adv), .rate(rate),
    .per_evt(per_evt)
  );

  assign wrap_evt = adv && (cnt == '1);

  rtc_pre_flags u_flags (
    .clk(clk), .rst(rst), .per_evt(per_evt), .upd_evt(wrap_evt),
    .clr(flag_clr), .per_en(per_en), .upd_en(upd_en),
    .per_flag(per_flag), .upd_flag(upd_flag), .irq(irq)
  );

  // R9
  upd_flag_follows_chk: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> upd_flag);
endmodule

// File: tb/tb_rtc_prescaler.sv
module tb_rtc_prescaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_32k = 1'b1;
  logic       ctl_we = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic [6:0] ctl_rdata;
  logic       per_en = 1'b1;
  logic       upd_en = 1'b1;
  logic       flag_clr = 1'b0;
  logic       upd_pulse, uip, per_flag, upd_flag, irq;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_prescaler dut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .per_en(per_en),
    .upd_en(upd_en), .flag_clr(flag_clr), .upd_pulse(upd_pulse),
    .uip(uip), .per_flag(per_flag), .upd_flag(upd_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Scoreboard monitor: each update pulse must match the next predicted edge.
  always @(negedge clk) begin
    if (!rst && upd_pulse) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected update", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R2 update timing", cyc, e);
      end
    end
  end

  task automatic wcfg(input logic [6:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wait_sb();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Release from hold with a rate code, then check the first periodic event.
  task automatic test_rate(input logic [3:0] code, input int e, input bit push);
    int ew;
    wcfg({3'b111, code});
    repeat (3) @(negedge clk);
    clr_flags();
    wcfg({3'b010, code});
    ew = cyc;
    if (push) exp_q.push_back(ew + 16384);
    if (e == 0) begin
      wait_to(ew + 600);
      chk(per_flag == 1'b0, "R6 rate 0 silent", per_flag, 0);
      chk(irq == 1'b0, "R10 no flag no irq", irq, 0);
    end else begin
      wait_to(ew + (1 << e) - 1);
      chk(per_flag == 1'b0, $sformatf("R5 R7 code %0d early", code), per_flag, 0);
      @(negedge clk);
      chk(per_flag == 1'b1, $sformatf("R5 R7 code %0d period", code), per_flag, 1);
      chk(irq == 1'b1, "R10 periodic irq", irq, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      summary();
    end
  end

  initial begin
    int c0, p1, ew1, ew2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctl_rdata == 7'h26, "R1 ctrl default", ctl_rdata, 7'h26);
    chk({upd_pulse, uip, per_flag, upd_flag, irq} == 5'b0, "R1 outputs idle",
        {upd_pulse, uip, per_flag, upd_flag, irq}, 0);
    rst = 1'b0;
    c0 = cyc;
    p1 = c0 + 16384;
    exp_q.push_back(p1);                       // R1 R3 first update
    wait_to(c0 + 31);
    chk(per_flag == 1'b0, "R5 default rate early", per_flag, 0);
    wait_to(c0 + 32);
    chk(per_flag == 1'b1, "R5 default rate 32 ticks", per_flag, 1);
    chk(irq == 1'b1, "R10 periodic irq enabled", irq, 1);
    wait_to(p1 - 9);
    chk(uip == 1'b0, "R8 uip before window", uip, 0);
    wait_to(p1 - 8);
    chk(uip == 1'b1, "R8 uip rises 8 ticks early", uip, 1);
    wait_to(p1 - 1);
    chk(uip == 1'b1 && upd_pulse == 1'b0, "R8 uip held", uip, 1);
    wait_to(p1);
    chk(upd_pulse == 1'b1, "R2 pulse present", upd_pulse, 1);
    chk(uip == 1'b0, "R8 uip low at pulse", uip, 0);
    chk(upd_flag == 1'b1, "R9 update flag set", upd_flag, 1);
    wait_sb();

    // R9 R10: clear and enable gating
    per_en = 1'b0;
    clr_flags();
    chk(upd_flag == 1'b0 && irq == 1'b0, "R9 clear flags", upd_flag, 0);
    while (per_flag == 1'b0) @(negedge clk);
    @(negedge clk);
    chk(irq == 1'b0, "R10 disabled periodic no irq", irq, 0);

    // R4 freeze, R11 tick gap
    wcfg(7'h06);
    ew1 = cyc;
    clr_flags();
    repeat (60) @(negedge clk);
    chk(per_flag == 1'b0, "R4 frozen no periodic", per_flag, 0);
    wcfg(7'h26);
    ew2 = cyc;
    @(negedge clk); tick_32k = 1'b0;
    repeat (40) @(negedge clk);
    tick_32k = 1'b1;
    exp_q.push_back(p1 + 32768 + (ew2 - ew1) + 40);  // R4 R11 shifted update
    wait_sb();
    chk(upd_flag == 1'b1 && irq == 1'b1, "R10 update irq", irq, 1);

    // Rate table and hold release
    per_en = 1'b1;
    test_rate(4'd3, 2, 1'b0);
    test_rate(4'd1, 7, 1'b0);
    test_rate(4'd8, 7, 1'b0);
    test_rate(4'd2, 8, 1'b0);
    test_rate(4'd9, 8, 1'b0);
    test_rate(4'd12, 11, 1'b0);
    test_rate(4'd0, 0, 1'b0);
    test_rate(4'd15, 14, 1'b1);                // R3 update 16384 after release
    wait_sb();
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule